// File: doc/BRIEF.md
# Long Mode Control Sequencer

This block holds the mode-control state of a 64-bit x86-style core: the protection and paging enables of the first control register, the address-extension enable of the fourth, and the long-mode enable of the extended feature register. Register writes arrive on a simple port, at most one per cycle. The block checks each write against the current state. A legal write updates the registers. An illegal one leaves every bit as it was and raises a one-cycle general-protection fault pulse.

The long-mode active flag cannot be written. The block sets it when paging comes on while the enable bit is already set, and clears it when paging goes off. Code-segment loads carry the L attribute. While long mode is active, that attribute picks between the 64-bit submode and the compatibility submode.

The block reports the current submode (real, legacy protected, compatibility or 64-bit) on a registered output. A registered read port returns any of the three registers.

Top module: `lm_ctrl_seq`

## Requirements
- R1: After reset (synchronous, active high), every register reads zero, the submode is real (code 0), the active flag is 0 and the fault output is 0.
- R2: The register selector codes are 0 for CR0, 1 for CR4 and 2 for the extended feature register. The modelled bits are protection enable at CR0[0], paging enable at CR0[31], address extension at CR4[5], long-mode enable at bit 8 and long-mode active at bit 10. All other bits read as zero. Read data appears one clock after the selector is sampled.
- R3: Long-mode active becomes 1 when a legal CR0 write turns paging on while the enable bit is already 1. Bit 10 of a feature-register write has no effect, and reads return the flag as it currently stands.
- R4: A CR0 write that turns paging on while the enable bit is 1 and address extension is 0 is faulted, and long mode stays inactive.
- R5: A CR0 write that turns paging on with the enable bit set while protection is currently off is faulted. So is any CR0 write with paging set and protection clear.
- R6: The submode codes are 0 real, 1 legacy protected, 2 compatibility and 3 64-bit. On activation the submode is compatibility until a code-segment load with L=1.
- R7: While long mode is active, a code-segment load with L=1 selects 64-bit and one with L=0 selects compatibility. Loads made while long mode is inactive have no effect.
- R8: A legal CR0 write that clears paging while long mode is active clears the active flag, and the submode becomes legacy protected from the next cycle.
- R9: A CR4 write that clears address extension while long mode is active is faulted. So is any feature-register write that changes the enable bit while paging is on.
- R10: A fault is a pulse lasting exactly one cycle, present in the cycle right after the rejected write's clock edge. Across that write no register bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Write register selector |
| wr_data | input | DATA_W | Write data |
| cs_load | input | 1 | Code-segment load strobe |
| cs_l | input | 1 | L attribute of the loaded code segment |
| rd_sel | input | SEL_W | Read register selector |
| rd_data | output | DATA_W | Registered read data |
| fault | output | 1 | General-protection fault pulse |
| lm_active | output | 1 | Long-mode active flag |
| submode | output | 2 | Current execution submode |

## Verification
On every cycle the assertions check several invariants. Long mode active always implies paging, protection, address extension and the enable bit. A fault comes only from a write and leaves every register stable. Activation never happens without protection already on. The 64-bit submode is never reported outside long mode. The bench scenarios are needed for the rest: the exact order of writes that legally enters and leaves long mode, the compatibility default after activation, loads ignored while inactive, readback of the derived and reserved bits, and the return to real mode after a reset taken mid-run.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int BIT_PE   = 0;
  localparam int BIT_PG   = 31;
  localparam int BIT_PAE  = 5;
  localparam int BIT_LME  = 8;
  localparam int BIT_LMA  = 10;

  localparam logic [1:0] SEL_CR0  = 2'd0;
  localparam logic [1:0] SEL_CR4  = 2'd1;
  localparam logic [1:0] SEL_EFER = 2'd2;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'd0,
    MODE_PROT   = 2'd1,
    MODE_COMPAT = 2'd2,
    MODE_64     = 2'd3
  } mode_e;

  typedef struct packed {
    logic pe;
    logic pg;
    logic pae;
    logic lme;
    logic lma;
  } ctl_t;
endpackage

// File: rtl/lm_wr_check.sv
module lm_wr_check
  import lm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 2
) (
  input  ctl_t              cur,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              nxt,
  output logic              gp
);
  ctl_t cand;
  logic bad;

  always_comb begin
    cand = cur;
    bad  = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        SEL_CR0: begin
          cand.pe = wr_data[BIT_PE];
          cand.pg = wr_data[BIT_PG];
          if (cand.pg && !cand.pe) bad = 1'b1;
          if (cand.pg && !cur.pg && cur.lme && (!cur.pae || !cur.pe)) bad = 1'b1;
          if (!cand.pg)    cand.lma = 1'b0;
          else if (!cur.pg) cand.lma = cur.lme;
        end
        SEL_CR4: begin
          cand.pae = wr_data[BIT_PAE];
          if (cur.lma && !cand.pae) bad = 1'b1;
        end
        SEL_EFER: begin
          cand.lme = wr_data[BIT_LME];
          if (cur.pg && (cand.lme != cur.lme)) bad = 1'b1;
        end
        default: ;
      endcase
    end
    nxt = bad ? cur : cand;
    gp  = bad;
  end
endmodule

// File: rtl/lm_state_regs.sv
module lm_state_regs
  import lm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t nxt,
  input  logic gp,
  input  logic cs_load,
  input  logic cs_l,
  output ctl_t cur,
  output logic csl_nxt,
  output logic fault
);
  logic csl_q;

  always_comb begin
    if (!nxt.lma)                 csl_nxt = 1'b0;
    else if (cs_load && cur.lma)  csl_nxt = cs_l;
    else                          csl_nxt = csl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      csl_q <= 1'b0;
      fault <= 1'b0;
    end else begin
      cur   <= nxt;
      csl_q <= csl_nxt;
      fault <= gp;
    end
  end

  // R3, R4: active long mode always sits on a full legal configuration
  p_lma_config_r4: assert property (@(posedge clk) disable iff (rst)
    cur.lma |-> (cur.pg && cur.pe && cur.pae && cur.lme));

  // R10: no register bit moves across a rejected write
  p_fault_stable_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(cur) && !$past(rst)));

  // R5: activation only with protection on before the write
  p_enter_from_prot_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cur.lma) |-> ($past(cur.pe) && !$past(rst)));
endmodule

// File: rtl/lm_submode.sv
module lm_submode
  import lm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctl_t       nxt,
  input  logic       csl_nxt,
  output logic [1:0] submode
);
  mode_e mode_d;

  always_comb begin
    if (!nxt.pe)       mode_d = MODE_REAL;
    else if (!nxt.lma) mode_d = MODE_PROT;
    else if (csl_nxt)  mode_d = MODE_64;
    else               mode_d = MODE_COMPAT;
  end

  always_ff @(posedge clk) begin
    if (rst) submode <= MODE_REAL;
    else     submode <= mode_d;
  end
endmodule

// File: rtl/lm_ctrl_seq.sv
module lm_ctrl_seq
  import lm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_load,
  input  logic              cs_l,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault,
  output logic              lm_active,
  output logic [1:0]        submode
);
  ctl_t cur, nxt;
  logic gp, csl_nxt;
  logic [DATA_W-1:0] rd_d;

  lm_wr_check #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .cur(cur), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nxt(nxt), .gp(gp)
  );

  lm_state_regs u_regs (
    .clk(clk), .rst(rst), .nxt(nxt), .gp(gp), .cs_load(cs_load),
    .cs_l(cs_l), .cur(cur), .csl_nxt(csl_nxt), .fault(fault)
  );

  lm_submode u_mode (
    .clk(clk), .rst(rst), .nxt(nxt), .csl_nxt(csl_nxt), .submode(submode)
  );

  assign lm_active = cur.lma;

  always_comb begin
    rd_d = '0;
    case (rd_sel)
      SEL_CR0: begin
        rd_d[BIT_PE] = cur.pe;
        rd_d[BIT_PG] = cur.pg;
      end
      SEL_CR4:  rd_d[BIT_PAE] = cur.pae;
      SEL_EFER: begin
        rd_d[BIT_LME] = cur.lme;
        rd_d[BIT_LMA] = cur.lma;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  // R10: a fault pulse always follows a register write
  p_fault_from_write_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(wr_en));

  // R6: the 64-bit submode is reported only inside long mode
  p_mode64_active_r6: assert property (@(posedge clk) disable iff (rst)
    (submode == MODE_64) |-> lm_active);

  // R8: leaving paging drops long mode and lands in protected mode
  p_exit_prot_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lm_active) && cur.pe |-> (submode == MODE_PROT));
endmodule

// File: tb/tb_lm_ctrl_seq.sv
`timescale 1ns/1ps
module tb_lm_ctrl_seq;
  localparam int DATA_W = 64;
  localparam int SEL_W  = 2;
  localparam int N      = 22;

  logic clk = 1'b0;
  logic rst, wr_en, cs_load, cs_l, fault, lm_active;
  logic [SEL_W-1:0]  wr_sel, rd_sel;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [1:0]        submode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lm_ctrl_seq #(.DATA_W(DATA_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cs_load(cs_load), .cs_l(cs_l), .rd_sel(rd_sel), .rd_data(rd_data),
    .fault(fault), .lm_active(lm_active), .submode(submode)
  );

  // {kind(1: 0 write, 1 cs load), sel(2), data(32), fault(1), mode(2), rdsel(2), readback(32)}
  localparam logic [71:0] VEC [N] = '{
    {1'b0, 2'd2, 32'h0000_0100, 1'b0, 2'd0, 2'd2, 32'h0000_0100},
    {1'b0, 2'd0, 32'h8000_0001, 1'b1, 2'd0, 2'd0, 32'h0000_0000},
    {1'b0, 2'd0, 32'h0000_0001, 1'b0, 2'd1, 2'd0, 32'h0000_0001},
    {1'b0, 2'd0, 32'h8000_0001, 1'b1, 2'd1, 2'd0, 32'h0000_0001},
    {1'b0, 2'd1, 32'h0000_0020, 1'b0, 2'd1, 2'd1, 32'h0000_0020},
    {1'b0, 2'd0, 32'h8000_0001, 1'b0, 2'd2, 2'd0, 32'h8000_0001},
    {1'b0, 2'd2, 32'h0000_0100, 1'b0, 2'd2, 2'd2, 32'h0000_0500},
    {1'b1, 2'd0, 32'h0000_0001, 1'b0, 2'd3, 2'd2, 32'h0000_0500},
    {1'b1, 2'd0, 32'h0000_0000, 1'b0, 2'd2, 2'd2, 32'h0000_0500},
    {1'b1, 2'd0, 32'h0000_0001, 1'b0, 2'd3, 2'd2, 32'h0000_0500},
    {1'b0, 2'd1, 32'h0000_0000, 1'b1, 2'd3, 2'd1, 32'h0000_0020},
    {1'b0, 2'd2, 32'h0000_0000, 1'b1, 2'd3, 2'd2, 32'h0000_0500},
    {1'b0, 2'd0, 32'h0000_0001, 1'b0, 2'd1, 2'd2, 32'h0000_0100},
    {1'b1, 2'd0, 32'h0000_0001, 1'b0, 2'd1, 2'd2, 32'h0000_0100},
    {1'b0, 2'd0, 32'h8000_0001, 1'b0, 2'd2, 2'd2, 32'h0000_0500},
    {1'b0, 2'd0, 32'h8000_0000, 1'b1, 2'd2, 2'd0, 32'h8000_0001},
    {1'b0, 2'd0, 32'h0000_0000, 1'b0, 2'd0, 2'd2, 32'h0000_0100},
    {1'b0, 2'd1, 32'hFFFF_FFFF, 1'b0, 2'd0, 2'd1, 32'h0000_0020},
    {1'b0, 2'd2, 32'h0000_0000, 1'b0, 2'd0, 2'd2, 32'h0000_0000},
    {1'b0, 2'd0, 32'h0000_0001, 1'b0, 2'd1, 2'd0, 32'h0000_0001},
    {1'b0, 2'd0, 32'h8000_0001, 1'b0, 2'd1, 2'd0, 32'h8000_0001},
    {1'b0, 2'd2, 32'h0000_0100, 1'b1, 2'd1, 2'd2, 32'h0000_0000}
  };

  string REQ [N] = '{
    "R2", "R5", "R2", "R4", "R2", "R3", "R3", "R7", "R7", "R7", "R9",
    "R9", "R8", "R7", "R6", "R5", "R8", "R2", "R2", "R2", "R3", "R9"
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] sel);
    wr_en = 1'b0; cs_load = 1'b0; rd_sel = sel;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    cs_load = 1'b0; cs_l = 1'b0; rd_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk(submode == 2'd0, "R1", "submode", 64'(submode), 64'd0);
    chk(fault == 1'b0, "R1", "fault", 64'(fault), 64'd0);
    chk(lm_active == 1'b0, "R1", "active", 64'(lm_active), 64'd0);
    for (int s = 0; s < 3; s++) begin
      read_reg(2'(s));
      chk(rd_data == '0, "R1", "reset readback", rd_data, 64'd0);
    end

    for (int i = 0; i < N; i++) begin
      logic [71:0] v;
      v = VEC[i];
      wr_en   = !v[71];
      cs_load = v[71];
      wr_sel  = v[70:69];
      wr_data = 64'(v[68:37]);
      cs_l    = v[37];
      @(posedge clk); #1;
      chk(fault == v[36], REQ[i], $sformatf("fault step %0d", i), 64'(fault), 64'(v[36]));
      chk(submode == v[35:34], REQ[i], $sformatf("submode step %0d", i),
          64'(submode), 64'(v[35:34]));
      chk(lm_active == (v[35:34] >= 2'd2), REQ[i], $sformatf("active step %0d", i),
          64'(lm_active), 64'(v[35:34] >= 2'd2));
      read_reg(v[33:32]);
      chk(rd_data == 64'(v[31:0]), REQ[i], $sformatf("readback step %0d", i),
          rd_data, 64'(v[31:0]));
      // R10: the pulse is gone one cycle later
      chk(fault == 1'b0, "R10", $sformatf("pulse width step %0d", i), 64'(fault), 64'd0);
    end

    // R1: reset taken mid-run returns to real mode with cleared registers
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(submode == 2'd0, "R1", "submode after reset", 64'(submode), 64'd0);
    read_reg(2'd0);
    chk(rd_data == '0, "R1", "CR0 after reset", rd_data, 64'd0);
    read_reg(2'd1);
    chk(rd_data == '0, "R1", "CR4 after reset", rd_data, 64'd0);

    finish_run();
  end
endmodule